// File: doc/BRIEF.md
# 4:2 Compressor Tree Multiplier

This block multiplies two unsigned operands of N bits and returns the full 2N-bit product. Every row of the partial-product array comes out of a plain AND array at the same time. The rows then pass through one or two levels of 4:2 compressors. Each compressor is two full adders in series. It takes four bits of the same weight plus a lateral carry from the column below, and returns a sum bit, an upward carry, and a lateral carry for the column above. Because the lateral carry-out depends only on the first adder's inputs, it never ripples along a row, so each level costs two full-adder delays. A single carry-propagate adder then merges the two remaining vectors.

With N = 8 there are two levels. The first level has two compressor rows, and each row takes four partial products. The second level has one compressor row, which takes the four vectors left by the first level. With N = 4 a single compressor row feeds the final adder. A parameter selects a registered output with synchronous reset, or a purely combinational output.

Top module: `mul42_tree`

## Requirements
- R1: With OUT_REG = 1, `p` equals the unsigned product of the `a` and `b` values sampled at the previous rising edge of `clk`, which is one cycle of latency.
- R2: A rising edge of `clk` with `rst_n` low sets `p` to 0, whatever the operand values.
- R3: In the compressor cell, with four data inputs `x[3:0]` and a lateral carry input `cin`, `sum + 2*(carry + cout)` equals the number of ones among those five inputs. This holds for all 32 input combinations.
- R4: The cell's lateral carry output `cout` is 1 exactly when at least two of `x[0]`, `x[1]` and `x[2]` are 1. It does not depend on `x[3]` or `cin`, so it cannot ripple along a row.
- R5: If either operand is zero, the product is zero.
- R6: If `b` is 1, the product equals `a`.
- R7: If both operands are all ones, the product is (2^N-1)^2, which is 0xFE01 for N = 8. No carry out of the top column is lost.
- R8: With N = 4, `p` is the correct 8-bit unsigned product for all 256 operand pairs.
- R9: With OUT_REG = 0, `p` follows the operands combinationally, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Synchronous active-low reset of the output register |
| a | input | N | Unsigned multiplicand |
| b | input | N | Unsigned multiplier, whose bit j selects partial-product row j |
| p | output | 2N | Unsigned product |

## Verification
In the registered variant, the product of operands presented before a rising edge appears one edge later. The bench therefore changes operands on a falling edge and reads `p` on the following falling edge, so exactly one rising edge lies between the two. A reset applied on a falling edge is also seen as a cleared product at the next falling edge. The combinational variant and the bare compressor cell have no latency. The bench reads them 1 ns after it changes their inputs, with no clock edge in that window.

// File: rtl/mul42_pkg.sv
package mul42_pkg;
    // Partial-product rows consumed by one compressor row.
    localparam int CELL_IN = 4;

    // Number of compressor rows on the first reduction level.
    function automatic int group_count(input int width);
        return width / CELL_IN;
    endfunction
endpackage

// File: rtl/mul42_fa.sv
module mul42_fa (
    input  logic i0,
    input  logic i1,
    input  logic i2,
    output logic s,
    output logic co
);
    always_comb begin
        s  = i0 ^ i1 ^ i2;
        co = (i0 & i1) | (i0 & i2) | (i1 & i2);
    end
endmodule

// File: rtl/mul42_cmp.sv
// One 4:2 compressor: two chained full adders. The lateral carry (cout)
// comes from the first adder only, so it never depends on cin.
module mul42_cmp (
    input  logic [3:0] x,
    input  logic       cin,
    output logic       sum,
    output logic       carry,
    output logic       cout
);
    logic mid;

    mul42_fa u_upper (
        .i0(x[0]),
        .i1(x[1]),
        .i2(x[2]),
        .s (mid),
        .co(cout)
    );

    mul42_fa u_lower (
        .i0(mid),
        .i1(x[3]),
        .i2(cin),
        .s (sum),
        .co(carry)
    );
endmodule

// File: rtl/mul42_row.sv
// A full-width row of 4:2 compressors. The lateral carries chain from column i
// to column i+1, and the bottom column receives zero. The upward carries leave
// pre-shifted by one place. The two bits that fall off the top are zero
// whenever the four inputs sum to less than 2**W.
module mul42_row #(
    parameter int W = 16
) (
    input  logic [W-1:0] r0,
    input  logic [W-1:0] r1,
    input  logic [W-1:0] r2,
    input  logic [W-1:0] r3,
    output logic [W-1:0] s,
    output logic [W-1:0] c,
    output logic [1:0]   spill_unused
);
    logic [W:0]   lat;
    logic [W-1:0] up;

    assign lat[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_col
        mul42_cmp u_cell (
            .x    ({r3[i], r2[i], r1[i], r0[i]}),
            .cin  (lat[i]),
            .sum  (s[i]),
            .carry(up[i]),
            .cout (lat[i+1])
        );
    end

    assign c            = {up[W-2:0], 1'b0};
    assign spill_unused = {lat[W], up[W-1]};
endmodule

// File: rtl/mul42_pp.sv
// AND-array partial products, each row already shifted to its weight.
module mul42_pp #(
    parameter int N = 8
) (
    input  logic [N-1:0]          a,
    input  logic [N-1:0]          b,
    output logic [N-1:0][2*N-1:0] rows
);
    for (genvar j = 0; j < N; j++) begin : g_row
        assign rows[j] = {{N{1'b0}}, a & {N{b[j]}}} << j;
    end
endmodule

// File: rtl/mul42_tree.sv
module mul42_tree
    import mul42_pkg::*;
#(
    parameter int N       = 8,
    parameter bit OUT_REG = 1'b1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   a,
    input  logic [N-1:0]   b,
    output logic [2*N-1:0] p
);
    localparam int W = 2 * N;
    localparam int G = group_count(N);

    logic [N-1:0][W-1:0] rows;
    logic [G-1:0][W-1:0] l1_s;
    logic [G-1:0][W-1:0] l1_c;
    logic [G-1:0][1:0]   l1_spill_unused;
    logic [W-1:0]        fin_s;
    logic [W-1:0]        fin_c;
    logic [W-1:0]        prod_c;

    mul42_pp #(.N(N)) u_pp (
        .a   (a),
        .b   (b),
        .rows(rows)
    );

    // First level: each group of four rows goes to one compressor row.
    for (genvar g = 0; g < G; g++) begin : g_l1
        mul42_row #(.W(W)) u_row (
            .r0          (rows[CELL_IN*g]),
            .r1          (rows[CELL_IN*g+1]),
            .r2          (rows[CELL_IN*g+2]),
            .r3          (rows[CELL_IN*g+3]),
            .s           (l1_s[g]),
            .c           (l1_c[g]),
            .spill_unused(l1_spill_unused[g])
        );
    end

    // Second level only when the first level leaves four vectors.
    if (G == 2) begin : g_l2
        logic [1:0] l2_spill_unused;
        mul42_row #(.W(W)) u_row (
            .r0          (l1_s[0]),
            .r1          (l1_c[0]),
            .r2          (l1_s[1]),
            .r3          (l1_c[1]),
            .s           (fin_s),
            .c           (fin_c),
            .spill_unused(l2_spill_unused)
        );
    end else begin : g_l1_only
        assign fin_s = l1_s[0];
        assign fin_c = l1_c[0];
    end

    // Final carry-propagate adder.
    assign prod_c = fin_s + fin_c;

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) p <= '0;
            else        p <= prod_c;
        end
    end else begin : g_comb
        assign p = prod_c;
    end
endmodule

// File: rtl/mul42_chk.sv
module mul42_chk #(
    parameter int N       = 8,
    parameter bit OUT_REG = 1'b1
) (
    input logic           clk,
    input logic           rst_n,
    input logic [N-1:0]   a,
    input logic [N-1:0]   b,
    input logic [2*N-1:0] p
);
    localparam int W = 2 * N;
    localparam logic [W-1:0] FULL_SQ = {{(N-1){1'b1}}, 1'b0, {(N-1){1'b0}}, 1'b1};

    logic [W-1:0] a_w;
    logic [W-1:0] b_w;
    assign a_w = {{N{1'b0}}, a};
    assign b_w = {{N{1'b0}}, b};

    if (OUT_REG) begin : g_seq
        assert_product_R1: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> p == $past(a_w) * $past(b_w));

        assert_reset_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(rst_n) |-> p == '0);

        assert_zero_operand_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (a == '0 || b == '0) |=> p == '0);

        assert_unit_operand_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (b_w == W'(1)) |=> p == $past(a_w));

        assert_full_square_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (&a && &b) |=> p == FULL_SQ);
    end
endmodule

bind mul42_tree mul42_chk #(.N(N), .OUT_REG(OUT_REG)) u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .a    (a),
    .b    (b),
    .p    (p)
);

// File: tb/sim_mul42_tree.sv
`timescale 1ns/1ps
module sim_mul42_tree;
    logic        clk   = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  a8 = '0, b8 = '0;
    logic [15:0] p8;
    logic [3:0]  a4 = '0, b4 = '0;
    logic [7:0]  p4;
    logic [3:0]  cx = '0;
    logic        ccin = 1'b0;
    logic        cs, cc, cco;
    int          checks = 0;
    int          fails  = 0;

    always #2 clk = ~clk;

    mul42_tree #(.N(8), .OUT_REG(1'b1)) u0 (.clk(clk), .rst_n(rst_n), .a(a8), .b(b8), .p(p8));
    mul42_tree #(.N(4), .OUT_REG(1'b0)) u1 (.clk(clk), .rst_n(rst_n), .a(a4), .b(b4), .p(p4));
    mul42_cmp u2 (.x(cx), .cin(ccin), .sum(cs), .carry(cc), .cout(cco));

    function automatic int ref_mul(input int x, input int y);
        return x * y;
    endfunction

    function automatic int ones(input logic [4:0] v);
        int n = 0;
        for (int k = 0; k < 5; k++) n += int'(v[k]);
        return n;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic apply8(input logic [7:0] x, input logic [7:0] y, input string req);
        @(negedge clk);
        a8 = x;
        b8 = y;
        @(negedge clk);
        check(req, int'(p8), ref_mul(int'(x), int'(y)));
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        // R2: reset holds the product at zero with live operands
        a8 = 8'hFF;
        b8 = 8'hFF;
        repeat (3) @(negedge clk);
        check("R2 reset", int'(p8), 0);
        rst_n = 1'b1;

        // R3, R4: compressor cell, all 32 input combinations
        for (int i = 0; i < 32; i++) begin
            logic [4:0] v;
            v    = 5'(i);
            cx   = v[3:0];
            ccin = v[4];
            #1;
            check("R3 cell count", int'(cs) + 2 * (int'(cc) + int'(cco)), ones(v));
            check("R4 lateral carry", int'(cco), (ones({2'b00, v[2:0]}) >= 2) ? 1 : 0);
        end

        // Directed corners
        apply8(8'h00, 8'hAB, "R5 zero a");
        apply8(8'h5C, 8'h00, "R5 zero b");
        apply8(8'hC3, 8'h01, "R6 unit b");
        @(negedge clk); a8 = 8'hFF; b8 = 8'hFF;
        @(negedge clk); check("R7 full square", int'(p8), 65025);
        apply8(8'h80, 8'h80, "R1 top bits");
        apply8(8'h01, 8'hFF, "R1 unit a");

        // R2: reset in mid-run, then recovery
        @(negedge clk); a8 = 8'hFF; b8 = 8'hFF; rst_n = 1'b0;
        @(negedge clk); check("R2 mid-run reset", int'(p8), 0);
        rst_n = 1'b1;
        @(negedge clk); check("R1 after reset", int'(p8), 65025);

        // R1: constrained random operands
        for (int i = 0; i < 1500; i++) begin
            apply8(8'($urandom_range(0, 255)), 8'($urandom_range(0, 255)), "R1 random");
        end

        // R1: exhaustive 8x8
        for (int i = 0; i < 65536; i++) begin
            apply8(i[15:8], i[7:0], "R1 exhaustive");
        end

        // R8: exhaustive 4x4 on the combinational variant
        for (int i = 0; i < 256; i++) begin
            a4 = i[7:4];
            b4 = i[3:0];
            #1;
            check("R8 4x4", int'(p4), ref_mul(int'(i[7:4]), int'(i[3:0])));
        end

        // R9: the combinational product settles between clock edges
        @(posedge clk);
        #0.5;
        a4 = 4'hD;
        b4 = 4'hB;
        #1;
        check("R9 no clock needed", int'(p4), 143);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule